// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block recovers characters from an asynchronous serial line. A free-running tick at sixteen times the bit rate drives it; the baud divider that makes the tick sits outside and is shared with the transmitter. The line first passes an optional whole-line polarity inversion and a synchronizer. A falling edge starts a start-bit check. When the start bit is confirmed, the block takes the data bits, an optional parity bit and one or two stop bits, each sampled at the middle of its bit period. The assembled character then moves into a receive buffer register.

The buffer raises a one-cycle interrupt pulse when it is loaded, and a full flag that a read strobe clears. Three sticky error flags report overrun, framing and parity faults, and a summary flag ORs them together. The overrun check is made early: it fires as soon as the seventh data bit of the next character has been sampled while the buffer is still unread. It does not wait for the end of that character. A data-only inversion flips just the character bits. The start, parity and stop bits are not affected by it.

Top module: `serial_rx_unit`

## Requirements
- R1: A character is received only while `rx_en` is 1. After a falling edge the line must still be low at the eighth tick (mid start bit). Otherwise the receiver returns to idle and produces nothing. Clearing `rx_en` aborts any character in progress.
- R2: `cfg_len` selects the character length: 0 = 7 bits, 1 = 8 bits, 2 = 9 bits (3 is treated as 8). Bits arrive LSB first. The first data bit lands in `rx_data[0]`, and unused upper bits of `rx_data` read 0.
- R3: Each character loaded into the buffer produces exactly one single-cycle `rx_irq` pulse and sets `rx_full`.
- R4: A `rd_strobe` pulse clears `rx_full`. If a load and a strobe fall in the same cycle, the load wins and `rx_full` stays 1.
- R5: If `rx_full` is 1, with no strobe, when the seventh data bit of a new character is sampled, `err_overrun` sets at once, before that character ends. That character is not loaded, gives no `rx_irq`, and `rx_data` keeps the earlier character.
- R6: `cfg_stop2` selects one stop bit (0) or two (1). If any expected stop bit is sampled low, `err_frame` is set.
- R7: `cfg_par` selects 0 = none, 1 = odd, 2 = even (3 = none). The count of ones over the character bits and the parity bit, taken as they appear on the line, must follow the selected rule. Otherwise `err_parity` is set.
- R8: Error flags are sticky while `rx_en` is 1 and are cleared when `rx_en` is 0. `err_sum` is 1 exactly when any of the three error flags is 1.
- R9: With `cfg_data_inv` = 1 the received character bits are inverted in `rx_data`. Start, parity and stop bits are interpreted uninverted.
- R10: With `cfg_line_inv` = 1 the whole `rxd` input is inverted before any other processing, so the idle pin level is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial input pin |
| rx_en | input | 1 | Receive enable; 0 also clears the error flags |
| cfg_len | input | 2 | Character length select |
| cfg_par | input | 2 | Parity mode select |
| cfg_stop2 | input | 1 | Two stop bits when 1 |
| cfg_data_inv | input | 1 | Invert character bits only |
| cfg_line_inv | input | 1 | Invert whole incoming line |
| rd_strobe | input | 1 | Buffer read strobe; clears the full flag |
| rx_data | output | 9 | Receive buffer contents |
| rx_full | output | 1 | Buffer holds an unread character |
| rx_irq | output | 1 | One-cycle pulse on buffer load |
| err_overrun | output | 1 | Overrun error flag |
| err_frame | output | 1 | Framing error flag |
| err_parity | output | 1 | Parity error flag |
| err_sum | output | 1 | OR of the three error flags |

## Verification
Two events can collide in one clock: loading the buffer and a read strobe. The bench provokes this by holding `rd_strobe` high through a whole character. It drops the strobe on the first falling edge at which `rx_irq` is seen, so the strobe was high on the loading edge and low after it. `rx_full` must then read 1. A second race, between a buffer read and the seventh data bit, is judged by checking `err_overrun` a few cycles before and after that bit's mid-point. The line-level sweep covers every combination of length, parity, stop count and both inversions, with expected data and parity computed in the bench.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [1:0] {
        LEN_7 = 2'd0,
        LEN_8 = 2'd1,
        LEN_9 = 2'd2,
        LEN_X = 2'd3
    } srx_len_e;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_ODD  = 2'd1,
        PAR_EVEN = 2'd2,
        PAR_NX   = 2'd3
    } srx_par_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } srx_state_e;

    localparam int CHAR_MAX = 9;
    localparam int BIDX_W   = $clog2(CHAR_MAX + 1);
    localparam int OVR_BIT  = 6;

    typedef struct packed {
        srx_len_e len;
        srx_par_e par;
        logic     stop2;
        logic     data_inv;
    } srx_cfg_t;

    typedef struct packed {
        logic [CHAR_MAX-1:0] data;
        logic                par_bad;
        logic                frm_bad;
    } srx_char_t;

    function automatic logic [BIDX_W-1:0] char_bits(input srx_len_e l);
        case (l)
            LEN_7:   return BIDX_W'(7);
            LEN_9:   return BIDX_W'(9);
            default: return BIDX_W'(8);
        endcase
    endfunction

    function automatic logic [CHAR_MAX-1:0] char_mask(input srx_len_e l);
        case (l)
            LEN_7:   return CHAR_MAX'(9'h07F);
            LEN_9:   return CHAR_MAX'(9'h1FF);
            default: return CHAR_MAX'(9'h0FF);
        endcase
    endfunction

    function automatic logic par_on(input srx_par_e p);
        return (p == PAR_ODD) || (p == PAR_EVEN);
    endfunction

endpackage

// File: rtl/srx_line_cond.sv
module srx_line_cond #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic invert,
    output logic line
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b1;
                    else     chain_q[0] <= pin ^ invert;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b1;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign line = chain_q[STAGES-1];
endmodule

// File: rtl/srx_bit_fsm.sv
module srx_bit_fsm
    import srx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      tick,
    input  logic      line,
    input  srx_cfg_t  cfg,
    output logic      done,
    output logic      bit7,
    output srx_char_t chr
);
    localparam int TW = $clog2(OSR);
    localparam logic [TW-1:0] MID  = TW'(OSR / 2 - 1);
    localparam logic [TW-1:0] LAST = TW'(OSR - 1);

    srx_state_e          state_q;
    logic [TW-1:0]       tcnt_q;
    logic [BIDX_W-1:0]   bidx_q;
    logic [CHAR_MAX-1:0] sh_q;
    logic                pacc_q;
    logic                frm_q;
    logic                stp_q;
    logic                done_q;
    logic                bit7_q;
    srx_char_t           chr_q;

    logic                frm_n;
    logic [CHAR_MAX-1:0] mask;
    assign frm_n = frm_q | ~line;
    assign mask  = char_mask(cfg.len);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tcnt_q  <= '0;
            bidx_q  <= '0;
            sh_q    <= '0;
            pacc_q  <= 1'b0;
            frm_q   <= 1'b0;
            stp_q   <= 1'b0;
            done_q  <= 1'b0;
            bit7_q  <= 1'b0;
            chr_q   <= '0;
        end else begin
            done_q <= 1'b0;
            bit7_q <= 1'b0;
            if (!en) begin
                state_q <= ST_IDLE;
            end else begin
                case (state_q)
                    ST_IDLE: begin
                        if (!line) begin
                            state_q <= ST_START;
                            tcnt_q  <= '0;
                        end
                    end
                    ST_START: begin
                        if (tick) begin
                            if (tcnt_q == MID) begin
                                if (!line) begin
                                    state_q <= ST_DATA;
                                    tcnt_q  <= '0;
                                    bidx_q  <= '0;
                                    sh_q    <= '0;
                                    pacc_q  <= 1'b0;
                                    frm_q   <= 1'b0;
                                    stp_q   <= 1'b0;
                                end else begin
                                    state_q <= ST_IDLE;
                                end
                            end else begin
                                tcnt_q <= tcnt_q + 1'b1;
                            end
                        end
                    end
                    ST_DATA: begin
                        if (tick) begin
                            tcnt_q <= tcnt_q + 1'b1;
                            if (tcnt_q == LAST) begin
                                sh_q[bidx_q] <= line;
                                pacc_q       <= pacc_q ^ line;
                                bidx_q       <= bidx_q + 1'b1;
                                if (bidx_q == BIDX_W'(OVR_BIT)) bit7_q <= 1'b1;
                                if (bidx_q == char_bits(cfg.len) - 1'b1)
                                    state_q <= par_on(cfg.par) ? ST_PAR : ST_STOP;
                            end
                        end
                    end
                    ST_PAR: begin
                        if (tick) begin
                            tcnt_q <= tcnt_q + 1'b1;
                            if (tcnt_q == LAST) begin
                                pacc_q  <= pacc_q ^ line;
                                state_q <= ST_STOP;
                            end
                        end
                    end
                    ST_STOP: begin
                        if (tick) begin
                            tcnt_q <= tcnt_q + 1'b1;
                            if (tcnt_q == LAST) begin
                                frm_q <= frm_n;
                                if (cfg.stop2 && !stp_q) begin
                                    stp_q <= 1'b1;
                                end else begin
                                    state_q       <= ST_IDLE;
                                    done_q        <= 1'b1;
                                    chr_q.data    <= (sh_q ^ (cfg.data_inv ? mask : '0)) & mask;
                                    chr_q.frm_bad <= frm_n;
                                    chr_q.par_bad <= par_on(cfg.par) &&
                                                     ((cfg.par == PAR_ODD) ? ~pacc_q : pacc_q);
                                end
                            end
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign done = done_q;
    assign bit7 = bit7_q;
    assign chr  = chr_q;

    // R1: disabling the receiver forces it back to idle
    assert_off_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !en |=> (state_q == ST_IDLE));

    // R3: completion is a single-cycle event
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R5: overrun point and completion never coincide
    assert_bit7_not_done_R5: assert property (@(posedge clk) disable iff (rst)
        !(bit7_q && done_q));
endmodule

// File: rtl/srx_rx_buffer.sv
module srx_rx_buffer
    import srx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                done,
    input  logic                bit7,
    input  srx_char_t           chr,
    input  logic                rd,
    output logic [CHAR_MAX-1:0] data,
    output logic                full,
    output logic                irq,
    output logic                ovr,
    output logic                frm,
    output logic                par,
    output logic                sum
);
    logic [CHAR_MAX-1:0] buf_q;
    logic full_q, irq_q, ovr_q, frm_q, par_q, ovr_char_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q      <= '0;
            full_q     <= 1'b0;
            irq_q      <= 1'b0;
            ovr_q      <= 1'b0;
            frm_q      <= 1'b0;
            par_q      <= 1'b0;
            ovr_char_q <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (rd) full_q <= 1'b0;
            if (bit7 && full_q && !rd) begin
                ovr_q      <= 1'b1;
                ovr_char_q <= 1'b1;
            end
            if (done) begin
                if (!ovr_char_q) begin
                    buf_q  <= chr.data;
                    full_q <= 1'b1;
                    irq_q  <= 1'b1;
                end
                ovr_char_q <= 1'b0;
                if (chr.frm_bad) frm_q <= 1'b1;
                if (chr.par_bad) par_q <= 1'b1;
            end
            if (!en) begin
                ovr_q      <= 1'b0;
                frm_q      <= 1'b0;
                par_q      <= 1'b0;
                ovr_char_q <= 1'b0;
            end
        end
    end

    assign data = buf_q;
    assign full = full_q;
    assign irq  = irq_q;
    assign ovr  = ovr_q;
    assign frm  = frm_q;
    assign par  = par_q;
    assign sum  = ovr_q | frm_q | par_q;

    // R3: an interrupt only follows a completed character
    assert_irq_after_done_R3: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> $past(done));

    // R4: a load wins over a simultaneous read strobe
    assert_load_beats_read_R4: assert property (@(posedge clk) disable iff (rst)
        (done && !ovr_char_q && en) |=> full_q);

    // R5: an overrun character raises no interrupt
    assert_ovr_no_irq_R5: assert property (@(posedge clk) disable iff (rst)
        (done && ovr_char_q && en) |=> !irq_q);

    // R8: disabling reception clears every error flag
    assert_clear_flags_R8: assert property (@(posedge clk) disable iff (rst)
        !en |=> !(ovr_q || frm_q || par_q));
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
    import srx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic       rx_en,
    input  logic [1:0] cfg_len,
    input  logic [1:0] cfg_par,
    input  logic       cfg_stop2,
    input  logic       cfg_data_inv,
    input  logic       cfg_line_inv,
    input  logic       rd_strobe,
    output logic [8:0] rx_data,
    output logic       rx_full,
    output logic       rx_irq,
    output logic       err_overrun,
    output logic       err_frame,
    output logic       err_parity,
    output logic       err_sum
);
    srx_cfg_t  cfg;
    srx_char_t chr;
    logic      line, done, bit7;

    assign cfg.len      = srx_len_e'(cfg_len);
    assign cfg.par      = srx_par_e'(cfg_par);
    assign cfg.stop2    = cfg_stop2;
    assign cfg.data_inv = cfg_data_inv;

    srx_line_cond #(.STAGES(SYNC_STAGES)) u_line (
        .clk(clk), .rst(rst), .pin(rxd), .invert(cfg_line_inv), .line(line)
    );

    srx_bit_fsm #(.OSR(OSR)) u_fsm (
        .clk(clk), .rst(rst), .en(rx_en), .tick(os_tick), .line(line),
        .cfg(cfg), .done(done), .bit7(bit7), .chr(chr)
    );

    srx_rx_buffer u_buf (
        .clk(clk), .rst(rst), .en(rx_en), .done(done), .bit7(bit7), .chr(chr),
        .rd(rd_strobe), .data(rx_data), .full(rx_full), .irq(rx_irq),
        .ovr(err_overrun), .frm(err_frame), .par(err_parity), .sum(err_sum)
    );
endmodule

// File: tb/serial_rx_unit_tb.sv
module serial_rx_unit_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b0;
    logic [1:0] cfg_len = 2'd1;
    logic [1:0] cfg_par = 2'd0;
    logic       cfg_stop2 = 1'b0;
    logic       cfg_data_inv = 1'b0;
    logic       cfg_line_inv = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [8:0] rx_data;
    logic       rx_full, rx_irq, err_overrun, err_frame, err_parity, err_sum;

    int checks = 0;
    int fails = 0;
    int irq_cnt = 0;
    bit finished = 0;
    localparam int BITCLK = 32;

    serial_rx_unit u_dut (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd), .rx_en(rx_en),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2),
        .cfg_data_inv(cfg_data_inv), .cfg_line_inv(cfg_line_inv),
        .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_full(rx_full),
        .rx_irq(rx_irq), .err_overrun(err_overrun), .err_frame(err_frame),
        .err_parity(err_parity), .err_sum(err_sum)
    );

    always #5 clk = ~clk;
    always @(posedge clk) os_tick <= ~os_tick;
    always @(posedge clk) if (rx_irq) irq_cnt <= irq_cnt + 1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_bit(input bit b, input int clks);
        rxd = b ^ cfg_line_inv;
        repeat (clks) @(negedge clk);
    endtask

    function automatic int nbits(input int l);
        return (l == 0) ? 7 : (l == 2) ? 9 : 8;
    endfunction

    task automatic send_frame(input logic [8:0] c, input bit bad_par, input bit bad_stop);
        int nb;
        logic [8:0] mask, lc;
        bit p;
        nb   = nbits(int'(cfg_len));
        mask = 9'((1 << nb) - 1);
        lc   = (c ^ (cfg_data_inv ? mask : 9'h0)) & mask;
        p    = ^lc;
        if (cfg_par == 2'd1) p = ~p;
        if (bad_par) p = ~p;
        drive_bit(1'b0, BITCLK);
        for (int i = 0; i < nb; i++) drive_bit(lc[i], BITCLK);
        if (cfg_par == 2'd1 || cfg_par == 2'd2) drive_bit(p, BITCLK);
        if (cfg_stop2) drive_bit(1'b1, BITCLK);
        if (bad_stop) begin
            drive_bit(1'b0, 24);
            drive_bit(1'b1, 8);
        end else begin
            drive_bit(1'b1, BITCLK);
        end
        drive_bit(1'b1, 16);
    endtask

    task automatic pulse_rd();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic setup(input int l, input int p, input bit s2, input bit di, input bit li);
        rx_en = 1'b0;
        @(negedge clk);
        cfg_len = 2'(l); cfg_par = 2'(p); cfg_stop2 = s2;
        cfg_data_inv = di; cfg_line_inv = li;
        rxd = ~li;
        repeat (4) @(negedge clk);
        rx_en = 1'b1;
        pulse_rd();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int base, idx;
        logic [8:0] ca, cb, mask;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R3 reset full", rx_full, 0);
        chk("R3 reset irq", rx_irq, 0);
        chk("R8 reset sum", err_sum, 0);

        // R1: frame while disabled is ignored
        setup(1, 0, 0, 0, 0);
        rx_en = 1'b0;
        base = irq_cnt;
        send_frame(9'h0A5, 0, 0);
        chk("R1 disabled no irq", irq_cnt, base);
        chk("R1 disabled no full", rx_full, 0);
        // R1: short glitch does not start a character
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
        drive_bit(1'b0, 8);
        drive_bit(1'b1, BITCLK * 12);
        chk("R1 glitch no irq", irq_cnt, base);
        chk("R1 glitch no full", rx_full, 0);

        // Sweep: R2 R6 R7 R8 R9 R10
        idx = 0;
        for (int li = 0; li < 2; li++)
        for (int di = 0; di < 2; di++)
        for (int l = 0; l < 3; l++)
        for (int p = 0; p < 3; p++)
        for (int s = 0; s < 2; s++) begin
            setup(l, p, s[0], di[0], li[0]);
            mask = 9'((1 << nbits(l)) - 1);
            ca = 9'(idx * 37 + 9'h15A);
            cb = ~ca;
            base = irq_cnt;
            send_frame(ca, 0, 0);
            chk("R2 R9 R10 data", rx_data, ca & mask);
            chk("R3 full", rx_full, 1);
            chk("R3 one irq", irq_cnt, base + 1);
            chk("R8 sum clean", err_sum, 0);
            pulse_rd();
            chk("R4 read clears", rx_full, 0);
            send_frame(cb, p != 0, p == 0);
            chk("R2 data b", rx_data, cb & mask);
            chk("R7 parity", err_parity, (p != 0) ? 1 : 0);
            chk("R6 frame", err_frame, (p == 0) ? 1 : 0);
            chk("R8 sum set", err_sum, 1);
            rx_en = 1'b0;
            @(negedge clk);
            @(negedge clk);
            chk("R8 flags cleared", err_sum, 0);
            idx++;
        end

        // R6: good two stop bits give no framing error (covered), R5 overrun
        setup(1, 0, 0, 0, 0);
        send_frame(9'h033, 0, 0);
        base = irq_cnt;
        fork
            send_frame(9'h0CC, 0, 0);
            begin
                repeat (BITCLK * 7 + 4) @(negedge clk);
                chk("R5 not before 7th bit", err_overrun, 0);
                repeat (BITCLK) @(negedge clk);
                chk("R5 at 7th bit", err_overrun, 1);
                chk("R5 sum", err_sum, 1);
            end
        join
        chk("R5 no irq", irq_cnt, base);
        chk("R5 buffer kept", rx_data, 9'h033);
        chk("R5 still full", rx_full, 1);

        // R5: read before 7th bit avoids overrun
        setup(1, 0, 0, 0, 0);
        send_frame(9'h011, 0, 0);
        base = irq_cnt;
        fork
            send_frame(9'h0EE, 0, 0);
            begin
                repeat (BITCLK * 3) @(negedge clk);
                pulse_rd();
            end
        join
        chk("R5 read in time no ovr", err_overrun, 0);
        chk("R5 read in time data", rx_data, 9'h0EE);
        chk("R3 irq after read", irq_cnt, base + 1);

        // R4: load and read strobe in the same cycle
        setup(1, 0, 0, 0, 0);
        rd_strobe = 1'b1;
        fork
            send_frame(9'h05C, 0, 0);
            begin
                while (!rx_irq) @(negedge clk);
                rd_strobe = 1'b0;
                @(negedge clk);
                chk("R4 load beats read", rx_full, 1);
                chk("R4 collide data", rx_data, 9'h05C);
                chk("R4 collide no ovr", err_overrun, 0);
            end
        join
        rd_strobe = 1'b0;

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule